// File: doc/BRIEF.md
# Branch Target Buffer with Two-Bit Direction Counters

This block predicts the next fetch address for conditional branches and direct jumps. The fetch stage presents the current program counter on every cycle. One cycle later the block returns a taken/not-taken guess and the target it has on record for that address. The table is direct-mapped. Each slot holds a valid flag, an address tag, a two-bit saturating direction counter and a word-aligned target. Jumps and conditional branches share the same slots and the same counters.

The execute stage resolves each instruction and reports the outcome on the update port: the instruction's address, whether it is a branch or jump, whether it was taken, its real target, and the guess that was made for it in fetch. The block then trains the table. One cycle later it raises a mispredict pulse together with the address fetch must restart from.

A small control stage combines that pulse with the pipeline's stall request and drives the hold and clear strobes of the two younger pipeline registers. A redirect always overrides a stall.

Top module: `btb_predictor`

## Requirements
- R1: A synchronous active-high reset clears every valid flag. In the cycle after reset, `pred_taken` and `mispredict` are 0, and no earlier training affects later lookups.
- R2: The table has 128 slots. It is indexed by `fetch_pc[8:2]` and tagged with `fetch_pc[31:9]`. The prediction for the address sampled at a clock edge appears on `pred_taken`/`pred_target` just after that edge.
- R3: `pred_taken` is 1 only when the slot is valid, the tag matches and the counter value is 2 or 3. In that case `pred_target` equals the stored target with bits [1:0] zero.
- R4: An update whose slot misses (invalid or tag differs) allocates the slot. Allocation writes the new tag and the target, sets the counter to 1 (weakly not taken) whatever the outcome, and sets the valid flag.
- R5: An update that hits increments the counter when taken and decrements it when not taken, saturating at 0 and 3. The stored target is replaced only when the outcome is taken.
- R6: An update with `ex_valid` = 0, or with `ex_is_ctrl` = 0, leaves the table unchanged.
- R7: `mispredict` rises in the cycle after a valid execute report in either of two cases. The first is when the actual direction (taken and control, a non-control instruction counting as not taken) differs from `ex_pred_taken`. The second is when both are taken and `ex_target` differs from `ex_pred_target`.
- R8: When `mispredict` is 1, `redirect_pc` equals the reported `ex_target` if the instruction was taken, and `ex_pc + 4` otherwise.
- R9: While `mispredict` is 1, `ifid_clear` and `idex_clear` are 1 and both hold strobes are 0, even when `stall_req` is 1. Otherwise the clears are 0 and both holds follow `stall_req`.
- R10: A lookup and an update that meet in the same clock edge on the same slot return the slot's contents from before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_pc | input | 32 | Address being fetched |
| pred_taken | output | 1 | Registered taken guess for the previous fetch address |
| pred_target | output | 32 | Registered target for the previous fetch address |
| ex_valid | input | 1 | Execute stage holds a real instruction |
| ex_pc | input | 32 | Address of the resolved instruction |
| ex_is_ctrl | input | 1 | Resolved instruction is a conditional branch or direct jump |
| ex_taken | input | 1 | Resolved direction |
| ex_target | input | 32 | Resolved target address |
| ex_pred_taken | input | 1 | Guess that fetch made for this instruction |
| ex_pred_target | input | 32 | Target that fetch used for this instruction |
| stall_req | input | 1 | Pipeline stall request |
| mispredict | output | 1 | One-cycle redirect pulse |
| redirect_pc | output | 32 | Restart address while mispredict is high |
| ifid_hold | output | 1 | Hold the fetch/decode register |
| ifid_clear | output | 1 | Clear the fetch/decode register |
| idex_hold | output | 1 | Hold the decode/execute register |
| idex_clear | output | 1 | Clear the decode/execute register |

## Verification
Two pairs of events can land on the same clock edge. The first is a redirect and a stall request. The bench sets `stall_req` high in exactly the cycle in which a wrong guess becomes visible, and expects the clears to win with both holds low. The second is a lookup and an update of the same slot. The bench drives `fetch_pc` equal to `ex_pc` while training, and expects the pre-update state in that cycle and the new state on the next lookup. A random phase mixes aliasing addresses, stalls and arbitrary reported guesses, and a behavioural model is compared on every cycle.

// File: rtl/btb_pkg.sv
package btb_pkg;

  typedef enum logic [1:0] {
    CTR_STRONG_NT = 2'd0,
    CTR_WEAK_NT   = 2'd1,
    CTR_WEAK_T    = 2'd2,
    CTR_STRONG_T  = 2'd3
  } ctr_e;

  // Saturating step of the direction counter.
  function automatic ctr_e ctr_step(input ctr_e cur, input logic taken);
    ctr_e nxt;
    nxt = cur;
    if (taken) begin
      if (cur != CTR_STRONG_T) nxt = ctr_e'(cur + 2'd1);
    end else begin
      if (cur != CTR_STRONG_NT) nxt = ctr_e'(cur - 2'd1);
    end
    return nxt;
  endfunction

  function automatic logic ctr_says_taken(input ctr_e c);
    return c[1];
  endfunction

endpackage

// File: rtl/btb_table.sv
module btb_table
  import btb_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  // fetch-side lookup
  input  logic [XLEN-1:0]  lk_pc,
  output logic             lk_taken,
  output logic [XLEN-1:0]  lk_target,
  // update-side combinational read
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [XLEN-IDX_W-3:0] rd_tag,
  output ctr_e             rd_ctr,
  // write port
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [XLEN-IDX_W-3:0] wr_tag,
  input  ctr_e             wr_ctr,
  input  logic             wr_tgt_en,
  input  logic [XLEN-3:0]  wr_tgt
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int TAG_W = XLEN - IDX_W - 2;
  localparam int TGT_W = XLEN - 2;

  logic             valid_q [DEPTH];
  logic [TAG_W-1:0] tag_mem [DEPTH];
  ctr_e             ctr_mem [DEPTH];
  logic [TGT_W-1:0] tgt_mem [DEPTH];

  logic [IDX_W-1:0] lk_idx;
  logic [TAG_W-1:0] lk_ptag;
  logic [1:0]       unused_lk_low;

  assign lk_idx        = lk_pc[IDX_W+1:2];
  assign lk_ptag       = lk_pc[XLEN-1:IDX_W+2];
  assign unused_lk_low = lk_pc[1:0];

  // Valid flags: the only state that needs a reset.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) valid_q[i] <= 1'b0;
    end else if (wr_en) begin
      valid_q[wr_idx] <= 1'b1;
    end
  end

  // Tag and counter storage, no reset.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_idx] <= wr_tag;
      ctr_mem[wr_idx] <= wr_ctr;
    end
  end

  // Target storage: one write port, one read-first registered read port.
  logic [TGT_W-1:0] lk_tgt_q;
  always_ff @(posedge clk) begin
    if (wr_tgt_en) tgt_mem[wr_idx] <= wr_tgt;
    lk_tgt_q <= tgt_mem[lk_idx];
  end

  // Registered lookup of the small fields.
  logic             lk_valid_q;
  logic [TAG_W-1:0] lk_tag_q;
  logic [TAG_W-1:0] lk_ptag_q;
  ctr_e             lk_ctr_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      lk_valid_q <= 1'b0;
      lk_tag_q   <= '0;
      lk_ptag_q  <= '0;
      lk_ctr_q   <= CTR_STRONG_NT;
    end else begin
      lk_valid_q <= valid_q[lk_idx];
      lk_tag_q   <= tag_mem[lk_idx];
      lk_ptag_q  <= lk_ptag;
      lk_ctr_q   <= ctr_mem[lk_idx];
    end
  end

  assign lk_taken  = lk_valid_q && (lk_tag_q == lk_ptag_q) && ctr_says_taken(lk_ctr_q);
  assign lk_target = {lk_tgt_q, 2'b00};

  // Update-side read.
  assign rd_valid = valid_q[rd_idx];
  assign rd_tag   = tag_mem[rd_idx];
  assign rd_ctr   = ctr_mem[rd_idx];

  // Checks
  logic [IDX_W-1:0] chk_widx_q;
  always_ff @(posedge clk) chk_widx_q <= wr_idx;

  assert_write_sets_valid_R4: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> valid_q[chk_widx_q]);

  assert_reset_empties_lookup_R1: assert property (@(posedge clk)
    rst |=> !lk_valid_q && !lk_taken);

endmodule

// File: rtl/btb_update.sv
module btb_update
  import btb_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ex_valid,
  input  logic [XLEN-1:0]  ex_pc,
  input  logic             ex_is_ctrl,
  input  logic             ex_taken,
  input  logic [XLEN-1:0]  ex_target,
  // table read
  output logic [IDX_W-1:0] rd_idx,
  input  logic             rd_valid,
  input  logic [XLEN-IDX_W-3:0] rd_tag,
  input  ctr_e             rd_ctr,
  // table write
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [XLEN-IDX_W-3:0] wr_tag,
  output ctr_e             wr_ctr,
  output logic             wr_tgt_en,
  output logic [XLEN-3:0]  wr_tgt
);
  localparam int TAG_W = XLEN - IDX_W - 2;

  logic [TAG_W-1:0] ex_tag;
  logic             hit;
  logic [3:0]       unused_low;

  assign unused_low = {ex_pc[1:0], ex_target[1:0]};
  assign ex_tag     = ex_pc[XLEN-1:IDX_W+2];
  assign rd_idx     = ex_pc[IDX_W+1:2];
  assign hit        = rd_valid && (rd_tag == ex_tag);

  always_comb begin
    wr_en     = ex_valid && ex_is_ctrl;
    wr_idx    = rd_idx;
    wr_tag    = ex_tag;
    wr_tgt    = ex_target[XLEN-1:2];
    wr_ctr    = hit ? ctr_step(rd_ctr, ex_taken) : CTR_WEAK_NT;
    wr_tgt_en = wr_en && (!hit || ex_taken);
  end

  assert_ctr_moves_one_step_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && hit) |-> (wr_ctr == rd_ctr || wr_ctr == ctr_e'(rd_ctr + 2'd1)
                        || wr_ctr == ctr_e'(rd_ctr - 2'd1)));

  assert_no_write_without_ctrl_R6: assert property (@(posedge clk) disable iff (rst)
    (!ex_valid || !ex_is_ctrl) |-> !wr_en && !wr_tgt_en);

endmodule

// File: rtl/btb_resolve.sv
module btb_resolve #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ex_valid,
  input  logic [XLEN-1:0] ex_pc,
  input  logic            ex_is_ctrl,
  input  logic            ex_taken,
  input  logic [XLEN-1:0] ex_target,
  input  logic            ex_pred_taken,
  input  logic [XLEN-1:0] ex_pred_target,
  output logic            mispredict,
  output logic [XLEN-1:0] redirect_pc
);
  logic actual_taken;
  logic dir_wrong;
  logic tgt_wrong;

  assign actual_taken = ex_is_ctrl && ex_taken;
  assign dir_wrong    = actual_taken != ex_pred_taken;
  assign tgt_wrong    = actual_taken && ex_pred_taken && (ex_target != ex_pred_target);

  always_ff @(posedge clk) begin
    if (rst) begin
      mispredict  <= 1'b0;
      redirect_pc <= '0;
    end else begin
      mispredict  <= ex_valid && (dir_wrong || tgt_wrong);
      redirect_pc <= actual_taken ? ex_target : ex_pc + XLEN'(4);
    end
  end

  assert_misp_follows_report_R7: assert property (@(posedge clk) disable iff (rst)
    mispredict |-> $past(ex_valid));

  assert_no_misp_when_idle_R7: assert property (@(posedge clk) disable iff (rst)
    !ex_valid |=> !mispredict);

endmodule

// File: rtl/btb_flush_ctl.sv
module btb_flush_ctl (
  input  logic clk,
  input  logic rst,
  input  logic stall_req,
  input  logic redirect,
  output logic ifid_hold,
  output logic ifid_clear,
  output logic idex_hold,
  output logic idex_clear
);
  // A redirect discards the younger instructions, so it beats a hold.
  always_comb begin
    ifid_clear = redirect;
    idex_clear = redirect;
    ifid_hold  = stall_req && !redirect;
    idex_hold  = stall_req && !redirect;
  end

  assert_clear_beats_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (ifid_clear || idex_clear) |-> !ifid_hold && !idex_hold);

  assert_stall_holds_both_R9: assert property (@(posedge clk) disable iff (rst)
    (stall_req && !redirect) |-> ifid_hold && idex_hold && !ifid_clear && !idex_clear);

endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
  import btb_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IDX_W = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [XLEN-1:0] fetch_pc,
  output logic            pred_taken,
  output logic [XLEN-1:0] pred_target,
  input  logic            ex_valid,
  input  logic [XLEN-1:0] ex_pc,
  input  logic            ex_is_ctrl,
  input  logic            ex_taken,
  input  logic [XLEN-1:0] ex_target,
  input  logic            ex_pred_taken,
  input  logic [XLEN-1:0] ex_pred_target,
  input  logic            stall_req,
  output logic            mispredict,
  output logic [XLEN-1:0] redirect_pc,
  output logic            ifid_hold,
  output logic            ifid_clear,
  output logic            idex_hold,
  output logic            idex_clear
);
  localparam int TAG_W = XLEN - IDX_W - 2;

  logic [IDX_W-1:0] rd_idx;
  logic             rd_valid;
  logic [TAG_W-1:0] rd_tag;
  ctr_e             rd_ctr;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [TAG_W-1:0] wr_tag;
  ctr_e             wr_ctr;
  logic             wr_tgt_en;
  logic [XLEN-3:0]  wr_tgt;

  btb_table #(.XLEN(XLEN), .IDX_W(IDX_W)) u_table (
    .clk       (clk),
    .rst       (rst),
    .lk_pc     (fetch_pc),
    .lk_taken  (pred_taken),
    .lk_target (pred_target),
    .rd_idx    (rd_idx),
    .rd_valid  (rd_valid),
    .rd_tag    (rd_tag),
    .rd_ctr    (rd_ctr),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_tag    (wr_tag),
    .wr_ctr    (wr_ctr),
    .wr_tgt_en (wr_tgt_en),
    .wr_tgt    (wr_tgt)
  );

  btb_update #(.XLEN(XLEN), .IDX_W(IDX_W)) u_update (
    .clk        (clk),
    .rst        (rst),
    .ex_valid   (ex_valid),
    .ex_pc      (ex_pc),
    .ex_is_ctrl (ex_is_ctrl),
    .ex_taken   (ex_taken),
    .ex_target  (ex_target),
    .rd_idx     (rd_idx),
    .rd_valid   (rd_valid),
    .rd_tag     (rd_tag),
    .rd_ctr     (rd_ctr),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_tag     (wr_tag),
    .wr_ctr     (wr_ctr),
    .wr_tgt_en  (wr_tgt_en),
    .wr_tgt     (wr_tgt)
  );

  btb_resolve #(.XLEN(XLEN)) u_resolve (
    .clk            (clk),
    .rst            (rst),
    .ex_valid       (ex_valid),
    .ex_pc          (ex_pc),
    .ex_is_ctrl     (ex_is_ctrl),
    .ex_taken       (ex_taken),
    .ex_target      (ex_target),
    .ex_pred_taken  (ex_pred_taken),
    .ex_pred_target (ex_pred_target),
    .mispredict     (mispredict),
    .redirect_pc    (redirect_pc)
  );

  btb_flush_ctl u_flush (
    .clk        (clk),
    .rst        (rst),
    .stall_req  (stall_req),
    .redirect   (mispredict),
    .ifid_hold  (ifid_hold),
    .ifid_clear (ifid_clear),
    .idex_hold  (idex_hold),
    .idex_clear (idex_clear)
  );

  assert_quiet_after_reset_R1: assert property (@(posedge clk)
    rst |=> !pred_taken && !mispredict);

endmodule

// File: tb/btb_predictor_test.sv
module btb_predictor_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] fetch_pc = 32'h0;
  logic        pred_taken;
  logic [31:0] pred_target;
  logic        ex_valid = 1'b0;
  logic [31:0] ex_pc = 32'h0;
  logic        ex_is_ctrl = 1'b0;
  logic        ex_taken = 1'b0;
  logic [31:0] ex_target = 32'h0;
  logic        ex_pred_taken = 1'b0;
  logic [31:0] ex_pred_target = 32'h0;
  logic        stall_req = 1'b0;
  logic        mispredict;
  logic [31:0] redirect_pc;
  logic        ifid_hold, ifid_clear, idex_hold, idex_clear;

  always #10 clk = ~clk;

  btb_predictor uut (
    .clk(clk), .rst(rst), .fetch_pc(fetch_pc),
    .pred_taken(pred_taken), .pred_target(pred_target),
    .ex_valid(ex_valid), .ex_pc(ex_pc), .ex_is_ctrl(ex_is_ctrl),
    .ex_taken(ex_taken), .ex_target(ex_target),
    .ex_pred_taken(ex_pred_taken), .ex_pred_target(ex_pred_target),
    .stall_req(stall_req), .mispredict(mispredict), .redirect_pc(redirect_pc),
    .ifid_hold(ifid_hold), .ifid_clear(ifid_clear),
    .idex_hold(idex_hold), .idex_clear(idex_clear)
  );

  int    vectors = 0;
  int    errors  = 0;
  string cur_req = "R1";
  bit    started = 0;

  // Behavioural reference
  bit          m_valid [128];
  int unsigned m_tag   [128];
  int          m_ctr   [128];
  logic [31:0] m_tgt   [128];
  logic        e_pt = 1'b0;
  logic [31:0] e_tgt = 32'h0;
  logic        e_misp = 1'b0;
  logic [31:0] e_redir = 32'h0;

  always @(posedge clk) begin
    int u;
    bit act;
    started = 1;
    if (rst) begin
      for (int i = 0; i < 128; i++) m_valid[i] = 0;
      e_pt = 0;
      e_misp = 0;
    end else begin
      u = int'(fetch_pc[8:2]);
      e_pt  = m_valid[u] && (m_tag[u] == fetch_pc[31:9]) && (m_ctr[u] >= 2);
      e_tgt = m_tgt[u];
      act = ex_is_ctrl && ex_taken;
      e_misp  = ex_valid && ((act != ex_pred_taken) ||
                (act && ex_pred_taken && ex_target != ex_pred_target));
      e_redir = act ? ex_target : ex_pc + 32'd4;
      if (ex_valid && ex_is_ctrl) begin
        u = int'(ex_pc[8:2]);
        if (m_valid[u] && m_tag[u] == ex_pc[31:9]) begin
          if (ex_taken) begin
            if (m_ctr[u] < 3) m_ctr[u]++;
            m_tgt[u] = {ex_target[31:2], 2'b00};
          end else if (m_ctr[u] > 0) begin
            m_ctr[u]--;
          end
        end else begin
          m_valid[u] = 1;
          m_tag[u]   = ex_pc[31:9];
          m_ctr[u]   = 1;
          m_tgt[u]   = {ex_target[31:2], 2'b00};
        end
      end
    end
  end

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      check("pred_taken", {31'd0, pred_taken}, {31'd0, e_pt});
      if (e_pt) check("pred_target", pred_target, e_tgt);
      check("mispredict", {31'd0, mispredict}, {31'd0, e_misp});
      if (e_misp) check("redirect_pc", redirect_pc, e_redir);
      check("ifid_clear", {31'd0, ifid_clear}, {31'd0, e_misp});
      check("idex_clear", {31'd0, idex_clear}, {31'd0, e_misp});
      check("ifid_hold", {31'd0, ifid_hold}, {31'd0, stall_req && !e_misp});
      check("idex_hold", {31'd0, idex_hold}, {31'd0, stall_req && !e_misp});
    end
  end

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic look(input logic [31:0] pc);
    fetch_pc = pc;
    tick();
  endtask

  task automatic ex(input logic [31:0] pc, input bit ctrl, input bit tk,
                    input logic [31:0] tgt, input bit ptk, input logic [31:0] ptgt);
    ex_valid = 1; ex_pc = pc; ex_is_ctrl = ctrl; ex_taken = tk;
    ex_target = tgt; ex_pred_taken = ptk; ex_pred_target = ptgt;
    tick();
    ex_valid = 0;
  endtask

  localparam logic [31:0] PA = 32'h0000_1040;
  localparam logic [31:0] PB = 32'h0000_1240; // same slot as PA, other tag
  localparam logic [31:0] T1 = 32'h0000_2000;
  localparam logic [31:0] T2 = 32'h0000_3008;

  initial begin
    repeat (3) tick();
    rst = 0;
    // R1: empty table after reset
    cur_req = "R1";
    look(PA); look(PA);

    // R4: first report allocates at weakly not taken
    cur_req = "R4";
    ex(PA, 1, 1, T1, 0, 0);
    look(PA); look(PA);
    // R2/R3: second taken -> counter 2 -> predicted with stored target
    cur_req = "R3";
    ex(PA, 1, 1, T1, 0, 0);
    look(PA); look(PA);
    cur_req = "R2";
    look(PA + 4); look(PA);
    // R5: saturate high, one not-taken keeps prediction
    cur_req = "R5";
    ex(PA, 1, 1, T1, 1, T1);
    ex(PA, 1, 1, T1, 1, T1);
    ex(PA, 1, 1, T1, 1, T1);
    ex(PA, 1, 0, T1, 1, T1);
    look(PA); look(PA);
    ex(PA, 1, 0, T1, 1, T1);
    ex(PA, 1, 0, T1, 0, 0);
    ex(PA, 1, 0, T1, 0, 0);
    look(PA); look(PA);
    ex(PA, 1, 1, T2, 0, 0);
    look(PA); look(PA);
    // R5: not-taken at hit keeps target
    ex(PA, 1, 1, T2, 0, 0);
    ex(PA, 1, 0, T1, 1, T2);
    look(PA); look(PA);
    // R7: taken with wrong target
    cur_req = "R7";
    ex(PA, 1, 1, T1, 1, T2);
    look(PA); look(PA);
    // R6: non-control reports change nothing; R8 redirect to pc+4
    cur_req = "R6";
    ex(PA, 0, 1, T2, 0, 0);
    ex(PA, 0, 0, T2, 0, 0);
    look(PA); look(PA);
    cur_req = "R8";
    ex(PA, 0, 0, T2, 1, T1);
    ex(PA, 1, 0, T2, 1, T1);
    look(PA);
    // R6 also: invalid report ignored
    cur_req = "R6";
    ex_valid = 0; ex_pc = PB; ex_is_ctrl = 1; ex_taken = 1; ex_target = T2;
    look(PB); look(PB);
    // R3: aliasing slot, tag differs
    cur_req = "R3";
    look(PB); look(PB);
    ex(PB, 1, 1, T2, 0, 0);
    ex(PB, 1, 1, T2, 0, 0);
    look(PB); look(PA); look(PA);
    // R9: stall and redirect in the same cycle, and stall alone
    cur_req = "R9";
    stall_req = 1;
    ex(PB, 1, 0, T2, 1, T2);
    tick(); tick();
    stall_req = 0;
    tick();
    // R10: same-edge lookup and update of one slot
    cur_req = "R10";
    fetch_pc = PB;
    ex(PB, 1, 1, T1, 0, 0);
    ex(PB, 1, 1, T1, 0, 0);
    look(PB); look(PB);
    // Random mix
    cur_req = "R7";
    for (int n = 0; n < 400; n++) begin
      logic [31:0] pc;
      pc = 32'h0000_1000 + {$urandom_range(0, 3), 9'd0} + {$urandom_range(0, 7), 2'b00};
      fetch_pc  = 32'h0000_1000 + {$urandom_range(0, 3), 9'd0} + {$urandom_range(0, 7), 2'b00};
      stall_req = $urandom_range(0, 3) == 0;
      ex_valid  = $urandom_range(0, 3) != 0;
      ex_pc = pc;
      ex_is_ctrl = $urandom_range(0, 4) != 0;
      ex_taken = $urandom_range(0, 1) == 1;
      ex_target = $urandom_range(0, 1) == 1 ? T1 : T2;
      ex_pred_taken = $urandom_range(0, 1) == 1;
      ex_pred_target = $urandom_range(0, 1) == 1 ? T1 : T2;
      tick();
    end
    ex_valid = 0; stall_req = 0;
    // R1: reset mid-run forgets training
    cur_req = "R1";
    ex(PA, 1, 1, T1, 0, 0);
    ex(PA, 1, 1, T1, 0, 0);
    rst = 1; tick(); rst = 0;
    look(PA); look(PA);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule